// File: doc/BRIEF.md
# Serial Port Register File and Interrupt Logic

This block is the bus-facing register set of a 16550-style serial port. A processor reaches eight byte-wide locations through a strided address window. The block holds the baud divisor, the line control, interrupt enable, queue control, modem control and scratch registers. It builds the interrupt identification byte and the line and modem status bytes, and it drives one level interrupt line. The serial shifter, the baud generator and any real queue sit elsewhere. This block only presents their state as though the transmitter can always take another byte.

Transmit bytes leave on a one-cycle valid strobe with no back-pressure, because the transmitter is always reported as ready. Received bytes enter through a valid/ready handshake into a single holding byte. `rx_ready` is high only while that byte is empty and no loopback byte is being inserted in the same cycle. A producer that sees `rx_ready` low must hold its byte and valid until a transfer happens. A processor read of the data location empties the holding byte. When loopback is on, bytes written to the data location go into the holding byte instead of to the transmit strobe.

Top module: `uart_regfile`

## Requirements
- R1: Location index = `req_addr / STRIDE`, rounded down. An access whose index is 8 or more changes no state and produces no read response.
- R2: After reset, the register values are: divisor 12, line control 0x03, interrupt enable 0, modem control 0, scratch 0. Identification reads 0x01, line status 0x60, modem status 0xB0, `irq` is 0 and `rx_ready` is 1.
- R3: While line control bit 7 is 1, location 0 reads and writes divisor bits 7:0 and location 1 reads and writes divisor bits 15:8. These accesses leave the data path and the interrupt enable register untouched.
- R4: A data write (location 0, line control bit 7 = 0, modem control bit 4 = 0) puts the byte on `tx_data`, with `tx_valid` high for exactly the cycle after the write.
- R5: A transmit-pending flag, shown as identification bit 1, is set by any of three events: a data write; an interrupt enable write that raises bit 1 from 0 to 1; or a modem control write with bit 3 = 1 while the flag is clear. Rewriting an enable bit 1 that is already 1 does not set it.
- R6: A read of location 2 returns the identification byte and clears the transmit-pending flag.
- R7: The receive side holds one byte. A transfer occurs when `rx_valid` and `rx_ready` are both high. While the byte is held, `rx_ready` is 0, line status bit 0 is 1 and identification bit 2 is 1.
- R8: A data read (line control bit 7 = 0) returns the held byte and empties the holding byte. With no byte held, a data read returns 0.
- R9: An interrupt is pending when (enable bit 1 AND transmit-pending) OR (enable bit 0 AND a byte is held). Identification bit 0 is the inverse of pending. `irq` is high only when an interrupt is pending and modem control bit 3 is 1.
- R10: With modem control bit 4 set, a data write loads the holding byte and leaves `tx_valid` low.
- R11: A write to location 2 stores queue-control bits 2:1, which appear as identification bits 7:6.
- R12: Line status (location 5) and modem status (location 6) store written values. Reads always show line status bits 6:5 as 1 and modem status bits 7, 5 and 4 as 1.
- R13: Every in-range read gives `rsp_valid` high for one cycle, with `rsp_data` valid, in the cycle after the request. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the strided window |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, the cycle after a read |
| rsp_data | output | 8 | Read data |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Holding byte can accept |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a receive byte that is offered while the holding byte is still full, and that must survive until the processor drains the holding byte. The bench keeps `rx_valid` high across a data read. It then checks that the first byte is returned, that `rx_ready` rises only after the pop, and that the waiting byte lands intact. The sticky transmit flag is driven through all three of its set paths, each followed by an identification read. The case where a repeated enable write must leave the flag clear is covered as well.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int unsigned REG_SLOTS = 8;

  typedef enum logic [2:0] {
    OFS_DATA       = 3'd0,
    OFS_IEN        = 3'd1,
    OFS_ID         = 3'd2,
    OFS_LINE       = 3'd3,
    OFS_MODEM_CTL  = 3'd4,
    OFS_LINE_STAT  = 3'd5,
    OFS_MODEM_STAT = 3'd6,
    OFS_SCRATCH    = 3'd7
  } reg_ofs_e;

  localparam int IEN_RX     = 0;
  localparam int IEN_TX     = 1;
  localparam int MCTL_GATE  = 3;
  localparam int MCTL_LOOP  = 4;
  localparam int LCTL_DLAB  = 7;

  localparam logic [7:0]  LST_FORCE  = 8'h60;
  localparam logic [7:0]  MST_FORCE  = 8'hB0;
  localparam logic [15:0] RESET_DIV  = 16'd12;
  localparam logic [7:0]  RESET_LCTL = 8'h03;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int STRIDE = 4
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit,
  output logic              wr_en,
  output logic              rd_en,
  output reg_ofs_e          ofs,
  output logic [REG_SLOTS-1:0] sel
);
  logic [ADDR_W-1:0] slot;

  assign slot  = req_addr / ADDR_W'(STRIDE);
  assign hit   = req_valid && (slot < ADDR_W'(REG_SLOTS));
  assign wr_en = hit && req_write;
  assign rd_en = hit && !req_write;
  assign ofs   = reg_ofs_e'(slot[2:0]);

  for (genvar i = 0; i < REG_SLOTS; i++) begin : g_sel
    assign sel[i] = hit && (slot[2:0] == 3'(i));
  end
endmodule

// File: rtl/uart_rf_rxhold.sv
module uart_rf_rxhold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              lb_push,
  input  logic [DATA_W-1:0] lb_data,
  input  logic              pop,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic take;

  assign in_ready = !full && !lb_push;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (lb_push) begin
      full <= 1'b1;
      data <= lb_data;
    end else if (take) begin
      full <= 1'b1;
      data <= in_data;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  // R7
  rx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> full && data == $past(in_data));

  // R7
  rx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop && !lb_push |=> full && $stable(data));
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic       tx_pend,
  input  logic       rx_pend,
  input  logic [1:0] ien,
  input  logic       gate,
  input  logic [1:0] qctl,
  output logic [7:0] id_value,
  output logic       irq
);
  logic tx_act, rx_act, any;

  assign tx_act   = ien[IEN_TX] && tx_pend;
  assign rx_act   = ien[IEN_RX] && rx_pend;
  assign any      = tx_act || rx_act;
  assign id_value = {qctl, 3'b000, rx_pend, tx_pend, !any};
  assign irq      = any && gate;
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              irq
);
  logic                 hit, wr_en, rd_en;
  reg_ofs_e             ofs;
  logic [REG_SLOTS-1:0] sel;

  logic [15:0] div_q;
  logic [7:0]  lctl_q, ien_q, mctl_q, lst_q, mst_q, scr_q;
  logic [1:0]  qctl_q;
  logic        tx_pend_q;

  logic        rx_full;
  logic [7:0]  rx_byte;
  logic [7:0]  id_value;
  logic [7:0]  rd_mux;

  logic dlab, loop_on;
  logic wr_dat, wr_ien, tx_rise, gate_set, rd_id, pop;

  uart_rf_decode #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .hit(hit), .wr_en(wr_en), .rd_en(rd_en), .ofs(ofs), .sel(sel)
  );

  assign dlab     = lctl_q[LCTL_DLAB];
  assign loop_on  = mctl_q[MCTL_LOOP];
  assign wr_dat   = wr_en && sel[OFS_DATA] && !dlab;
  assign wr_ien   = wr_en && sel[OFS_IEN] && !dlab;
  assign tx_rise  = wr_ien && req_wdata[IEN_TX] && !ien_q[IEN_TX];
  assign gate_set = wr_en && sel[OFS_MODEM_CTL] && req_wdata[MCTL_GATE] && !tx_pend_q;
  assign rd_id    = rd_en && sel[OFS_ID];
  assign pop      = rd_en && sel[OFS_DATA] && !dlab;

  uart_rf_rxhold #(.DATA_W(8)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_data(rx_data), .in_ready(rx_ready),
    .lb_push(wr_dat && loop_on), .lb_data(req_wdata),
    .pop(pop), .full(rx_full), .data(rx_byte)
  );

  uart_rf_irq u_irq (
    .tx_pend(tx_pend_q), .rx_pend(rx_full), .ien(ien_q[1:0]),
    .gate(mctl_q[MCTL_GATE]), .qctl(qctl_q),
    .id_value(id_value), .irq(irq)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= RESET_DIV;
      lctl_q <= RESET_LCTL;
      ien_q  <= '0;
      mctl_q <= '0;
      qctl_q <= '0;
      scr_q  <= '0;
    end else if (wr_en) begin
      unique case (ofs)
        OFS_DATA:      if (dlab) div_q[7:0]  <= req_wdata;
        OFS_IEN:       if (dlab) div_q[15:8] <= req_wdata;
                       else      ien_q       <= req_wdata;
        OFS_ID:        qctl_q <= req_wdata[2:1];
        OFS_LINE:      lctl_q <= req_wdata;
        OFS_MODEM_CTL: mctl_q <= req_wdata;
        OFS_SCRATCH:   scr_q  <= req_wdata;
        default:       ;
      endcase
    end
  end

  // status registers: writable, always-ready bits restored on each access
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lst_q <= LST_FORCE;
      mst_q <= MST_FORCE;
    end else begin
      if (wr_en && sel[OFS_LINE_STAT])  lst_q <= req_wdata;
      else if (hit)                     lst_q <= lst_q | LST_FORCE;
      if (wr_en && sel[OFS_MODEM_STAT]) mst_q <= req_wdata;
      else if (hit)                     mst_q <= mst_q | MST_FORCE;
    end
  end

  // sticky transmit-pending flag
  always_ff @(posedge clk) begin
    if (!rst_n)                           tx_pend_q <= 1'b0;
    else if (wr_dat || tx_rise || gate_set) tx_pend_q <= 1'b1;
    else if (rd_id)                       tx_pend_q <= 1'b0;
  end

  // transmit strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= wr_dat && !loop_on;
      if (wr_dat && !loop_on) tx_data <= req_wdata;
    end
  end

  // read path
  always_comb begin
    unique case (ofs)
      OFS_DATA:       rd_mux = dlab ? div_q[7:0] : (rx_full ? rx_byte : 8'h00);
      OFS_IEN:        rd_mux = dlab ? div_q[15:8] : ien_q;
      OFS_ID:         rd_mux = id_value;
      OFS_LINE:       rd_mux = lctl_q;
      OFS_MODEM_CTL:  rd_mux = mctl_q;
      OFS_LINE_STAT:  rd_mux = {lst_q[7:1] | LST_FORCE[7:1], rx_full};
      OFS_MODEM_STAT: rd_mux = mst_q | MST_FORCE;
      default:        rd_mux = scr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_mux;
    end
  end

  // R1
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hit |=> !rsp_valid && !tx_valid && $stable(lctl_q) && $stable(scr_q) && $stable(div_q));

  // R3
  div_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && sel[OFS_DATA] && dlab |=> div_q[7:0] == $past(req_wdata) && !tx_valid);

  // R4
  tx_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat && !loop_on |=> tx_valid && tx_data == $past(req_wdata));

  // R6
  id_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id |=> !tx_pend_q);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mctl_q[MCTL_GATE] && (tx_pend_q || rx_full));

  // R13
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_en));
endmodule

// File: tb/sim_uart_regfile.sv
module sim_uart_regfile;
  localparam int ADDR_W = 6;
  localparam int STRIDE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rsp_valid, tx_valid, rx_ready, irq;
  logic [7:0] rsp_data, tx_data;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  uart_regfile #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_raw(input logic wr, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input int ofs, input logic [7:0] d);
    bus_raw(1'b1, ADDR_W'(ofs * STRIDE), d);
  endtask

  task automatic rd(input int ofs, output logic [7:0] d);
    bus_raw(1'b0, ADDR_W'(ofs * STRIDE), 8'h00);
    d = rsp_data;
    check("R13 rsp_valid", int'(rsp_valid), 1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R2 irq", int'(irq), 0);
    check("R2 rx_ready", int'(rx_ready), 1);
    rd(3, v); check("R2 line ctl", v, 8'h03);
    rd(1, v); check("R2 enable", v, 8'h00);
    rd(4, v); check("R2 modem ctl", v, 8'h00);
    rd(2, v); check("R2 ident", v, 8'h01);
    rd(5, v); check("R2 line stat", v, 8'h60);
    rd(6, v); check("R2 modem stat", v, 8'hB0);
    rd(7, v); check("R2 scratch", v, 8'h00);
  endtask

  task automatic t_divisor();
    logic [7:0] v;
    wr(3, 8'h83);
    rd(0, v); check("R3 div low reset", v, 8'h0C);
    rd(1, v); check("R3 div high reset", v, 8'h00);
    wr(0, 8'h34);
    check("R3 no tx on div write", int'(tx_valid), 0);
    wr(1, 8'h12);
    rd(0, v); check("R3 div low", v, 8'h34);
    rd(1, v); check("R3 div high", v, 8'h12);
    wr(3, 8'h03);
    rd(1, v); check("R3 enable untouched", v, 8'h00);
    rd(2, v); check("R3 no pending", v, 8'h01);
  endtask

  task automatic t_transmit();
    logic [7:0] v;
    wr(0, 8'h5A);
    check("R4 tx_valid", int'(tx_valid), 1);
    check("R4 tx_data", int'(tx_data), 8'h5A);
    @(negedge clk);
    check("R4 tx_valid single", int'(tx_valid), 0);
    rd(2, v); check("R5 data write sets pend", v, 8'h03);
    rd(2, v); check("R6 read clears pend", v, 8'h01);
  endtask

  task automatic t_txpend();
    logic [7:0] v;
    wr(1, 8'h02);
    check("R9 gate closed", int'(irq), 0);
    wr(4, 8'h08);
    check("R9 irq on", int'(irq), 1);
    rd(2, v); check("R5 enable rise", v, 8'h02);
    check("R6 irq drops", int'(irq), 0);
    wr(4, 8'h08);
    check("R5 gate set", int'(irq), 1);
    rd(2, v); check("R5 gate ident", v, 8'h02);
    wr(1, 8'h02);
    check("R5 no rise no set", int'(irq), 0);
    rd(2, v); check("R5 still clear", v, 8'h01);
    wr(1, 8'h00);
    wr(4, 8'h00);
    rd(2, v);
  endtask

  task automatic t_receive();
    logic [7:0] v;
    wr(1, 8'h01);
    wr(4, 8'h08);
    rd(2, v); check("R9 no rx pending", v, 8'h03);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'hA5;
    @(negedge clk); rx_data = 8'h77;
    check("R7 ready low when full", int'(rx_ready), 0);
    check("R9 rx irq", int'(irq), 1);
    rd(5, v); check("R7 line stat bit0", v, 8'h61);
    rd(2, v); check("R7 ident rx", v, 8'h04);
    rd(0, v); check("R8 pop first", v, 8'hA5);
    @(negedge clk); rx_valid = 1'b0;
    rd(0, v); check("R7 waiting byte", v, 8'h77);
    check("R7 ready after pop", int'(rx_ready), 1);
    rd(0, v); check("R8 empty read", v, 8'h00);
    check("R9 irq off", int'(irq), 0);
    wr(1, 8'h00);
    wr(4, 8'h00);
  endtask

  task automatic t_loopback();
    logic [7:0] v;
    wr(4, 8'h10);
    wr(0, 8'h3C);
    check("R10 no tx", int'(tx_valid), 0);
    rd(5, v); check("R10 held", v, 8'h61);
    rd(0, v); check("R10 byte", v, 8'h3C);
    wr(4, 8'h00);
    rd(2, v);
  endtask

  task automatic t_queue_ctl();
    logic [7:0] v;
    wr(2, 8'h07);
    rd(2, v); check("R11 both", v, 8'hC1);
    wr(2, 8'h02);
    rd(2, v); check("R11 one", v, 8'h41);
    wr(2, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] v;
    wr(5, 8'h00);
    rd(5, v); check("R12 line forced", v, 8'h60);
    wr(5, 8'h82);
    rd(5, v); check("R12 line stored", v, 8'hE2);
    wr(6, 8'h00);
    rd(6, v); check("R12 modem forced", v, 8'hB0);
    wr(6, 8'h04);
    rd(6, v); check("R12 modem stored", v, 8'hB4);
  endtask

  task automatic t_range();
    logic [7:0] v;
    wr(7, 8'h9C);
    bus_raw(1'b1, ADDR_W'(29), 8'h4D);
    rd(7, v); check("R1 truncating stride", v, 8'h4D);
    bus_raw(1'b1, ADDR_W'(32), 8'hFF);
    bus_raw(1'b1, ADDR_W'(44), 8'hFF);
    rd(7, v); check("R1 scratch kept", v, 8'h4D);
    rd(3, v); check("R1 line ctl kept", v, 8'h03);
    bus_raw(1'b0, ADDR_W'(36), 8'h00);
    check("R1 no response", int'(rsp_valid), 0);
    bus_raw(1'b1, ADDR_W'(0), 8'h11);
    check("R13 write no response", int'(rsp_valid), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_divisor();
    t_transmit();
    t_txpend();
    t_receive();
    t_loopback();
    t_queue_ctl();
    t_status();
    t_range();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule